// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block sits between a MAC-side nibble stream and a copper line driver. It accepts 4-bit nibbles, one per 25 MHz nibble period, and emits one three-level line symbol per 125 MHz symbol enable. Each packet is framed in the 5-bit code-group domain by an opening delimiter pair and a closing delimiter pair. The code groups are shifted out one bit per symbol enable, and the resulting serial stream is scrambled and then MLT-3 coded. Between packets the idle group of five ones is sent without a break, and these idle groups pass through the scrambler and line coder as well.

The upstream side is a valid/ready stream. `in_valid` high means a packet is in progress. The block raises `in_ready` for exactly one cycle at each code-group boundary, which is the symbol enable on which the last bit of the current group goes out. A nibble is taken on that cycle when `in_valid` is also high. The source holds `in_valid` and `in_data` steady until it sees the transfer. A packet ends when `in_valid` is low at a boundary. Back-pressure therefore amounts to pacing: the source is offered one slot every five symbol enables, and none during the closing delimiter tail.

Top module: `fe_tx_line_encoder`

## Requirements
- R1: While reset is held and until the first symbol enable after it, `line_sym` is 0 (2'b00) and `in_ready` is low.
- R2: `in_ready` is high only in a cycle where `sym_en` is high and that enable is the fifth, tenth, fifteenth and so on after reset (enable index mod 5 equal to 4, counting from 0). It is never high on the boundary that begins the closing R group.
- R3: When no packet is in progress, every 5-bit group on the unscrambled serial stream is 11111. The first group after reset is also 11111.
- R4: The first two nibbles accepted in a packet are not sent. The group 11000 takes the place of the first and the group 10001 takes the place of the second.
- R5: Every later nibble accepted in the packet is sent as its code group, with the most significant bit first. The groups for values 0 to F are, in order: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: When `in_valid` is low at a boundary during a packet, the group 01101 is sent, then the group 00111, and idle groups follow immediately.
- R7: Each serial bit is XORed with the feedback bit f = s[10] ^ s[8] of an 11-bit state s. s then shifts left by one and takes f into bit 0. s resets to 11'h1A5 and never becomes zero.
- R8: `line_sym` is a 2-bit signed level: 2'b00 = 0, 2'b01 = +1, 2'b11 = -1. A scrambled bit of 1 moves the level to the next state of the cycle 0, +1, 0, -1. A scrambled bit of 0 holds the level. The new level appears at the clock edge of the enable that consumes the bit.
- R9: `line_sym` changes only at a clock edge where `sym_en` was high.
- R10: A packet that has only one accepted nibble is sent as 11000, then 01101, then 00111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_en | input | 1 | Symbol-rate enable; the serial section advances once per high cycle |
| in_valid | input | 1 | Packet in progress; a nibble is presented |
| in_data | input | 4 | Nibble to transmit |
| in_ready | output | 1 | Nibble slot open this cycle (code-group boundary) |
| line_sym | output | 2 | Three-level line symbol, two's complement |

## Verification
`in_ready` is combinational on `sym_en` and the bit position, so the bench checks it in the same cycle as the enable it drives. The line level for a bit is due in the register updated by that bit's enable, and the bench reads it at the next falling clock edge. A nibble accepted at a boundary appears over the next five enables, so each five-symbol slice after reset lines up with exactly one code group. The bench recovers each bit from the level changes. It descrambles the bits with its own model of the state register and compares whole groups against the frame token list it built from the nibbles it sent. On cycles without an enable, it checks that the level is unchanged.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;
  localparam int GW = 5;

  localparam logic [GW-1:0] GRP_IDLE = 5'b11111;
  localparam logic [GW-1:0] GRP_SOPA = 5'b11000;
  localparam logic [GW-1:0] GRP_SOPB = 5'b10001;
  localparam logic [GW-1:0] GRP_EOPA = 5'b01101;
  localparam logic [GW-1:0] GRP_EOPB = 5'b00111;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SECOND,
    FR_BODY,
    FR_TAIL
  } fr_state_t;

  function automatic logic [GW-1:0] nib_to_group(input logic [3:0] n);
    logic [GW-1:0] g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/fe_tx_framer.sv
module fe_tx_framer
  import fe_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_en,
  input  logic       in_valid,
  input  logic [3:0] in_data,
  output logic       in_ready,
  output logic       raw_bit
);
  localparam int CW = $clog2(GW);
  localparam logic [CW-1:0] LAST = CW'(GW - 1);

  logic [CW-1:0] pos_q;
  logic [GW-1:0] shreg_q;
  fr_state_t     st_q, st_d;
  logic [GW-1:0] grp_d;
  logic          boundary;

  assign boundary = sym_en && (pos_q == LAST);
  assign in_ready = boundary && (st_q != FR_TAIL);
  assign raw_bit  = shreg_q[GW-1];

  always_comb begin
    grp_d = GRP_IDLE;
    st_d  = st_q;
    case (st_q)
      FR_IDLE: begin
        if (in_valid) begin
          grp_d = GRP_SOPA;
          st_d  = FR_SECOND;
        end
      end
      FR_SECOND: begin
        if (in_valid) begin
          grp_d = GRP_SOPB;
          st_d  = FR_BODY;
        end else begin
          grp_d = GRP_EOPA;
          st_d  = FR_TAIL;
        end
      end
      FR_BODY: begin
        if (in_valid) begin
          grp_d = nib_to_group(in_data);
        end else begin
          grp_d = GRP_EOPA;
          st_d  = FR_TAIL;
        end
      end
      default: begin
        grp_d = GRP_EOPB;
        st_d  = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      shreg_q <= GRP_IDLE;
      st_q    <= FR_IDLE;
    end else if (sym_en) begin
      if (pos_q == LAST) begin
        pos_q   <= '0;
        shreg_q <= grp_d;
        st_q    <= st_d;
      end else begin
        pos_q   <= pos_q + 1'b1;
        shreg_q <= {shreg_q[GW-2:0], 1'b1};
      end
    end
  end
endmodule

// File: rtl/fe_tx_scrambler.sv
module fe_tx_scrambler #(
  parameter int               SW   = 11,
  parameter int               TAP  = 9,
  parameter logic [SW-1:0]    SEED = 11'h1A5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);
  localparam logic [SW-1:0] ZERO = '0;

  logic [SW-1:0] s_q, s_d;
  logic          fb;

  assign fb   = s_q[SW-1] ^ s_q[TAP-1];
  assign dout = din ^ fb;

  always_comb begin
    s_d = {s_q[SW-2:0], fb};
    if (s_d == ZERO) s_d = SEED;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  s_q <= SEED;
    else if (en) s_q <= s_d;
  end
endmodule

// File: rtl/fe_tx_mlt3.sv
module fe_tx_mlt3 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       din,
  output logic [1:0] level
);
  logic [1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         ph_q <= 2'd0;
    else if (en && din) ph_q <= ph_q + 2'd1;
  end

  always_comb begin
    case (ph_q)
      2'd1:    level = 2'b01;
      2'd3:    level = 2'b11;
      default: level = 2'b00;
    endcase
  end
endmodule

// File: rtl/fe_tx_line_encoder.sv
module fe_tx_line_encoder #(
  parameter int            SCR_W    = 11,
  parameter int            SCR_TAP  = 9,
  parameter logic [10:0]   SCR_SEED = 11'h1A5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_en,
  input  logic       in_valid,
  input  logic [3:0] in_data,
  output logic       in_ready,
  output logic [1:0] line_sym
);
  logic raw_bit;
  logic scr_bit;

  fe_tx_framer u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_en   (sym_en),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .raw_bit  (raw_bit)
  );

  fe_tx_scrambler #(
    .SW   (SCR_W),
    .TAP  (SCR_TAP),
    .SEED (SCR_W'(SCR_SEED))
  ) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sym_en),
    .din   (raw_bit),
    .dout  (scr_bit)
  );

  fe_tx_mlt3 u_mlt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sym_en),
    .din   (scr_bit),
    .level (line_sym)
  );
endmodule

// File: rtl/fe_tx_checker.sv
module fe_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_en,
  input logic       in_ready,
  input logic [1:0] line_sym
);
  p_ready_on_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> sym_en);

  p_ready_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  p_hold_no_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> $stable(line_sym));

  p_level_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_sym != 2'b10);

  p_pos_not_to_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sym == 2'b01) |=> (line_sym != 2'b11));

  p_neg_not_to_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sym == 2'b11) |=> (line_sym != 2'b01));

  p_reset_level_r1: assert property (@(posedge clk)
    !rst_n |=> (line_sym == 2'b00));
endmodule

bind fe_tx_line_encoder fe_tx_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sym_en   (sym_en),
  .in_ready (in_ready),
  .line_sym (line_sym)
);

// File: tb/sim_fe_tx_line_encoder.sv
module sim_fe_tx_line_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_data = 4'h0;
  logic       in_ready;
  logic [1:0] line_sym;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  fe_tx_line_encoder u0 (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .line_sym(line_sym)
  );

  localparam int NFR = 4;
  localparam int MAXG = 1024;
  logic [4:0] groups [MAXG];
  int n_bits = 0;

  function automatic int fr_len(input int f);
    case (f)
      0: return 18;
      1: return 1;
      2: return 6;
      default: return 2;
    endcase
  endfunction

  function automatic logic [3:0] fr_dat(input int f, input int i);
    if (f == 0) return (i < 2) ? 4'h5 : 4'(i - 2);
    return 4'((i * 7 + f) % 16);
  endfunction

  function automatic logic [4:0] code_of(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001;
      4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011;
      4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011;
      4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  function automatic logic [1:0] lvl_of(input int p);
    case (p % 4)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [10:0] s;
    logic [1:0]  prev_lvl;
    logic [4:0]  cur;
    int ph, n_in, fi, ni, gap, cyc, gi;
    bit prev_en, active, cur_en;

    s = 11'h1A5; ph = 0; n_in = 0; fi = 0; ni = 0; gap = 120;
    prev_en = 0; active = 0; prev_lvl = 2'b00; cur = '0;

    repeat (5) @(negedge clk);
    check(line_sym == 2'b00, "R1 level in reset", line_sym, 0);
    check(in_ready == 1'b0, "R1 ready in reset", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(line_sym == 2'b00, "R1 level after reset", line_sym, 0);
    check(in_ready == 1'b0, "R1 ready after reset", in_ready, 0);

    for (cyc = 0; cyc < 6000; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (prev_en) begin
        logic sb, rb, f;
        if (line_sym == prev_lvl) sb = 1'b0;
        else if (line_sym == lvl_of(ph + 1)) begin sb = 1'b1; ph++; end
        else begin
          sb = 1'b0;
          check(1'b0, "R8 level step", line_sym, lvl_of(ph + 1));
        end
        f = s[10] ^ s[8];
        rb = sb ^ f;
        s = {s[9:0], f};
        if (s == 11'd0) check(1'b0, "R7 state zero", 0, 1);
        cur = {cur[3:0], rb};
        n_bits++;
        if (n_bits % 5 == 0 && n_bits / 5 <= MAXG) groups[n_bits / 5 - 1] = cur;
      end else if (cyc > 0) begin
        check(line_sym == prev_lvl, "R9 hold without enable", line_sym, prev_lvl);
      end
      prev_lvl = line_sym;

      cur_en = (cyc % 2 == 0);
      if (!active && fi < NFR) begin
        if (gap > 0) gap--;
        else begin active = 1; ni = 0; end
      end
      sym_en   = cur_en;
      in_valid = active;
      in_data  = active ? fr_dat(fi, ni) : 4'h0;
      #1;
      if (in_ready) begin
        check(sym_en && (n_in % 5 == 4), "R2 ready placement", n_in % 5, 4);
        if (in_valid) begin
          ni++;
          if (ni == fr_len(fi)) begin active = 0; fi++; gap = 60; end
        end
      end
      if (cur_en) n_in++;
      prev_en = cur_en;
    end

    gi = 0;
    check(groups[0] == 5'b11111, "R3 first group idle", groups[0], 5'h1f);
    for (int f = 0; f < NFR; f++) begin
      int len, nt;
      len = fr_len(f);
      nt = (len == 1) ? 3 : len + 2;
      while (gi < n_bits / 5 && groups[gi] == 5'b11111) gi++;
      for (int k = 0; k < nt; k++) begin
        logic [4:0] e;
        string r;
        if (k == 0) begin e = 5'b11000; r = "R4 first delimiter"; end
        else if (len == 1) begin
          e = (k == 1) ? 5'b01101 : 5'b00111;
          r = "R10 short packet";
        end
        else if (k == 1) begin e = 5'b10001; r = "R4 second delimiter"; end
        else if (k < len) begin e = code_of(fr_dat(f, k)); r = "R5 data group"; end
        else if (k == len) begin e = 5'b01101; r = "R6 first end group"; end
        else begin e = 5'b00111; r = "R6 second end group"; end
        check(groups[gi] == e, r, groups[gi], e);
        gi++;
      end
      check(groups[gi] == 5'b11111, "R6 idle after end", groups[gi], 5'h1f);
      check(groups[gi + 1] == 5'b11111, "R3 idle between packets", groups[gi + 1], 5'h1f);
    end
    while (gi < n_bits / 5) begin
      check(groups[gi] == 5'b11111, "R3 trailing idle", groups[gi], 5'h1f);
      gi++;
    end
    done = 1;
    report();
  end
endmodule